// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave Front End

This block is the slave side of a three-wire serial memory: a select line, a host-driven shift clock and a data input, plus a data output that has its own output enable so it can share a wire with the data input. The pins are sampled in the local clock domain. A transaction opens with a high start bit after any number of zeros. A two-bit operation code follows, then the word address, and for the two write-type operations the data word. The `org` input picks between wide words and half-width words, and a half-width address is one bit longer. Reads are served through a combinational read port on an external word array. Writes, clears and the enable and disable of writing are decoded here. Every change to the array is handed to a separate self-timed engine as a one-cycle request when the host drops the select line.

The control FSM has the states ST_IDLE (deselected), ST_HUNT (waiting for a start bit), ST_OPC (two operation bits), ST_ADDR (address bits), ST_DATA (write data bits), ST_READ (streaming read data) and ST_HOLD (instruction complete, waiting for deselect). Its transitions are:
- Any state goes to ST_IDLE when the select line is low.
- ST_IDLE goes to ST_HUNT when the select line is high.
- ST_HUNT goes to ST_OPC on a clock rise with the input high, but only while the engine is idle.
- ST_OPC goes to ST_ADDR after the second operation bit.
- After the last address bit, ST_ADDR goes to ST_READ for a read. It goes to ST_DATA for a single write or a fill-all, and to ST_HOLD for every other operation.
- ST_DATA goes to ST_HOLD after the last data bit.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset and whenever the select line has been low for two local clock cycles, `do_oe` is low and no request is issued. With no request outstanding, raising the select line leaves `do_oe` low.
- R2: Zero bits clocked in before the start bit while selected are ignored. The instruction that follows decodes normally.
- R3: Operation code 2'b10 is a read. After the last address bit `do_oe` rises and `do_o` carries one 0 bit. Each later shift-clock rise presents the next bit of the addressed word, MSB first. With `org`=1 words are 16 bits and addresses 6 bits. With `org`=0 words are 8 bits (returned in `rd_data[7:0]`) and addresses 7 bits.
- R4: While selected and clocked beyond the last bit, the read moves on to the next address with no further 0 bit. It wraps from the highest address (63 or 127) to address 0.
- R5: Writing is disabled after reset. Operation 2'b00 with top address bits 2'b00 disables it again. While disabled, write-type instructions issue no request and arm no status.
- R6: Operation 2'b00 with top address bits 2'b11 enables writing. Operation 2'b01 then issues a request with `wr_kind`=0, the address and the data. The request appears only after the select line has gone low.
- R7: Operation 2'b11 issues `wr_kind`=1 with its address. Operation 2'b00 with top bits 2'b10 issues `wr_kind`=2. Operation 2'b00 with top bits 2'b01 takes a data word and issues `wr_kind`=3 with that data.
- R8: A select-line drop before an instruction is complete discards it and issues no request. The next instruction decodes from its own start bit.
- R9: After a request, selecting the device before any start bit drives `do_oe`=1 with `do_o`=0 while `eng_busy` is high and `do_o`=1 once it is low. A start bit clocked in while ready releases `do_oe`.
- R10: While `eng_busy` is high, start bits are ignored. The status stays on `do_o` and no read begins.
- R11: `wr_req` is high for exactly one clock cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Select line, active high |
| sk | input | 1 | Host shift clock |
| di | input | 1 | Serial data input |
| org | input | 1 | 1: wide words, 0: half-width words |
| do_o | output | 1 | Serial data output |
| do_oe | output | 1 | Output enable for `do_o` |
| rd_addr | output | AW16+1 | Read-port word address |
| rd_data | input | DW | Read-port word, low half used when `org`=0 |
| eng_busy | input | 1 | Write engine is working |
| wr_req | output | 1 | One-cycle request to the write engine |
| wr_kind | output | 2 | 0 write word, 1 clear word, 2 clear all, 3 write all |
| wr_addr | output | AW16+1 | Request address |
| wr_data | output | DW | Request data, low half in `org`=0 |

## Verification
Reads are tried at the first, a middle and the last address in both word organizations. This tells a correct MSB-first order and width apart from shifted or truncated ones. Streaming reads across the top address separate a true wrap from an overrun, and they show the 0 bit appearing only once. Each write-type instruction is sent with writing enabled and with it disabled, and with the select line dropped mid-instruction. These patterns separate the request kind, address and data from a wrongly decoded or leaked request. A read sent while the engine is busy tells ignored start bits apart from a read that starts anyway.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_HOLD
    } mw_state_e;

    typedef enum logic [1:0] {
        OPC_SPECIAL = 2'b00,
        OPC_WRITE   = 2'b01,
        OPC_READ    = 2'b10,
        OPC_ERASE   = 2'b11
    } mw_opc_e;

    typedef enum logic [1:0] {
        SUB_LOCK   = 2'b00,
        SUB_FILL   = 2'b01,
        SUB_WIPE   = 2'b10,
        SUB_UNLOCK = 2'b11
    } mw_sub_e;

    typedef enum logic [1:0] {
        KIND_WORD_WR  = 2'd0,
        KIND_WORD_CLR = 2'd1,
        KIND_ALL_CLR  = 2'd2,
        KIND_ALL_WR   = 2'd3
    } mw_kind_e;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/mw_rd_path.sv
module mw_rd_path #(
    parameter int AW16 = 6,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            org,
    input  logic            start_i,
    input  logic [AW16:0]   start_addr_i,
    input  logic            step_i,
    input  logic            active_i,
    input  logic [DW-1:0]   rd_data_i,
    output logic [AW16:0]   rd_addr_o,
    output logic            bit_o,
    output logic            oe_o
);

    localparam int AW8  = AW16 + 1;
    localparam int HW   = DW / 2;
    localparam int CW   = $clog2(DW + 1);
    localparam logic [AW8-1:0] MASK16 = AW8'((1 << AW16) - 1);

    logic [AW8-1:0] addr_q;
    logic [DW-1:0]  sh_q;
    logic [DW-1:0]  ld_word;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  wbits;
    logic [AW8-1:0] addr_inc;
    logic           need_q;
    logic           bit_q;
    logic           oe_q;

    // Align the word so its MSB always sits in the top bit of the shifter.
    always_comb begin
        ld_word  = org ? rd_data_i : {rd_data_i[HW-1:0], {HW{1'b0}}};
        wbits    = org ? CW'(DW) : CW'(HW);
        addr_inc = org ? ((addr_q + AW8'(1)) & MASK16) : (addr_q + AW8'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            sh_q   <= '0;
            cnt_q  <= '0;
            need_q <= 1'b0;
            bit_q  <= 1'b0;
            oe_q   <= 1'b0;
        end else if (start_i) begin
            addr_q <= start_addr_i;
            oe_q   <= 1'b1;
            bit_q  <= 1'b0;
            need_q <= 1'b1;
            cnt_q  <= '0;
        end else if (!active_i) begin
            oe_q   <= 1'b0;
            need_q <= 1'b0;
        end else if (step_i) begin
            if (need_q) begin
                bit_q  <= ld_word[DW-1];
                sh_q   <= {ld_word[DW-2:0], 1'b0};
                cnt_q  <= wbits - CW'(1);
                need_q <= 1'b0;
            end else begin
                bit_q <= sh_q[DW-1];
                sh_q  <= {sh_q[DW-2:0], 1'b0};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    addr_q <= addr_inc;
                    need_q <= 1'b1;
                end
            end
        end
    end

    assign rd_addr_o = addr_q;
    assign bit_o     = bit_q;
    assign oe_o      = oe_q;

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
    import mw_eeprom_pkg::*;
#(
    parameter int AW16 = 6,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs,
    input  logic            sk,
    input  logic            di,
    input  logic            org,
    output logic            do_o,
    output logic            do_oe,
    output logic [AW16:0]   rd_addr,
    input  logic [DW-1:0]   rd_data,
    input  logic            eng_busy,
    output logic            wr_req,
    output logic [1:0]      wr_kind,
    output logic [AW16:0]   wr_addr,
    output logic [DW-1:0]   wr_data
);

    localparam int AW8  = AW16 + 1;
    localparam int HW   = DW / 2;
    localparam int MAXB = (DW > AW8) ? DW : AW8;
    localparam int CNTW = $clog2(MAXB + 1);

    // Pin sampling and shift-clock edge detection
    logic [2:0] sync_q;
    logic       cs_s, sk_s, di_s, sk_d, sk_rise;

    mw_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs, sk, di}),
        .q_o   (sync_q)
    );

    assign cs_s = sync_q[2];
    assign sk_s = sync_q[1];
    assign di_s = sync_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_d <= 1'b0;
        else        sk_d <= sk_s;
    end

    assign sk_rise = sk_s & ~sk_d;

    // Control state and datapath registers
    mw_state_e      state, state_nx;
    mw_opc_e        opc_q;
    mw_kind_e       pend_kind, kind_q;
    logic [AW8-1:0] addr_sh, addr_nx, waddr_q;
    logic [DW-1:0]  data_sh, wdata_q;
    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] addr_bits, word_bits;
    logic           cnt_end;
    logic           we_en, stat_armed, pend_vld, req_q;
    mw_sub_e        top2;

    // Read path hookup
    logic           rd_start, rd_step, rd_active, rd_bit, rd_oe;
    logic           stat_on;

    always_comb begin
        addr_nx   = {addr_sh[AW8-2:0], di_s};
        addr_bits = org ? CNTW'(AW16) : CNTW'(AW8);
        word_bits = org ? CNTW'(DW) : CNTW'(HW);
        cnt_end   = (cnt == '0);
        top2      = org ? mw_sub_e'(addr_nx[AW16-1:AW16-2])
                        : mw_sub_e'(addr_nx[AW8-1:AW8-2]);
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (!cs_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_HUNT;
                ST_HUNT: begin
                    if (sk_rise && di_s && !eng_busy) state_nx = ST_OPC;
                end
                ST_OPC: begin
                    if (sk_rise && cnt_end) state_nx = ST_ADDR;
                end
                ST_ADDR: begin
                    if (sk_rise && cnt_end) begin
                        case (opc_q)
                            OPC_READ:  state_nx = ST_READ;
                            OPC_WRITE: state_nx = ST_DATA;
                            OPC_ERASE: state_nx = ST_HOLD;
                            default:   state_nx = (top2 == SUB_FILL) ? ST_DATA : ST_HOLD;
                        endcase
                    end
                end
                ST_DATA: begin
                    if (sk_rise && cnt_end) state_nx = ST_HOLD;
                end
                ST_READ: state_nx = ST_READ;
                ST_HOLD: state_nx = ST_HOLD;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Shift, count and decode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q      <= OPC_SPECIAL;
            addr_sh    <= '0;
            data_sh    <= '0;
            cnt        <= '0;
            we_en      <= 1'b0;
            stat_armed <= 1'b0;
            pend_vld   <= 1'b0;
            pend_kind  <= KIND_WORD_WR;
            req_q      <= 1'b0;
            kind_q     <= KIND_WORD_WR;
            waddr_q    <= '0;
            wdata_q    <= '0;
        end else begin
            req_q <= 1'b0;
            if (!cs_s) begin
                if (state == ST_HOLD && pend_vld && we_en) begin
                    req_q      <= 1'b1;
                    kind_q     <= pend_kind;
                    waddr_q    <= addr_sh;
                    wdata_q    <= data_sh;
                    stat_armed <= 1'b1;
                end
                pend_vld <= 1'b0;
            end else begin
                case (state)
                    ST_HUNT: begin
                        if (sk_rise && di_s && !eng_busy) begin
                            stat_armed <= 1'b0;
                            opc_q      <= OPC_SPECIAL;
                            cnt        <= CNTW'(1);
                        end
                    end
                    ST_OPC: begin
                        if (sk_rise) begin
                            opc_q <= mw_opc_e'({opc_q[0], di_s});
                            if (cnt_end) begin
                                cnt     <= addr_bits - CNTW'(1);
                                addr_sh <= '0;
                            end else begin
                                cnt <= cnt - CNTW'(1);
                            end
                        end
                    end
                    ST_ADDR: begin
                        if (sk_rise) begin
                            addr_sh <= addr_nx;
                            if (cnt_end) begin
                                data_sh <= '0;
                                cnt     <= word_bits - CNTW'(1);
                                case (opc_q)
                                    OPC_WRITE: pend_kind <= KIND_WORD_WR;
                                    OPC_ERASE: begin
                                        pend_kind <= KIND_WORD_CLR;
                                        pend_vld  <= 1'b1;
                                    end
                                    OPC_SPECIAL: begin
                                        case (top2)
                                            SUB_UNLOCK: we_en <= 1'b1;
                                            SUB_LOCK:   we_en <= 1'b0;
                                            SUB_WIPE: begin
                                                pend_kind <= KIND_ALL_CLR;
                                                pend_vld  <= 1'b1;
                                            end
                                            default: pend_kind <= KIND_ALL_WR;
                                        endcase
                                    end
                                    default: ;
                                endcase
                            end else begin
                                cnt <= cnt - CNTW'(1);
                            end
                        end
                    end
                    ST_DATA: begin
                        if (sk_rise) begin
                            data_sh <= {data_sh[DW-2:0], di_s};
                            if (cnt_end) pend_vld <= 1'b1;
                            else         cnt <= cnt - CNTW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_start  = cs_s && (state == ST_ADDR) && sk_rise && cnt_end && (opc_q == OPC_READ);
    assign rd_step   = cs_s && (state == ST_READ) && sk_rise;
    assign rd_active = cs_s && (state == ST_READ);

    mw_rd_path #(.AW16(AW16), .DW(DW)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .org          (org),
        .start_i      (rd_start),
        .start_addr_i (addr_nx),
        .step_i       (rd_step),
        .active_i     (rd_active),
        .rd_data_i    (rd_data),
        .rd_addr_o    (rd_addr),
        .bit_o        (rd_bit),
        .oe_o         (rd_oe)
    );

    // Output process
    always_comb begin
        stat_on = cs_s && (state == ST_HUNT) && stat_armed;
        do_oe   = stat_on | rd_oe;
        do_o    = stat_on ? ~eng_busy : (rd_oe & rd_bit);
        wr_req  = req_q;
        wr_kind = kind_q;
        wr_addr = waddr_q;
        wr_data = wdata_q;
    end

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_eeprom_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_s,
    input logic      sk_rise,
    input logic      eng_busy,
    input mw_state_e state,
    input logic      do_oe,
    input logic      wr_req
);

    assert_dout_released_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!cs_s && $past(!cs_s)) |-> !do_oe
    );

    assert_req_after_deselect_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        wr_req |-> $past(!cs_s)
    );

    assert_busy_blocks_start_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cs_s && state == ST_HUNT && eng_busy && sk_rise) |=> (state != ST_OPC)
    );

    assert_req_single_cycle_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req
    );

    assert_read_needs_select_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_READ) |-> $past(cs_s)
    );

endmodule

bind mw_eeprom_slave mw_eeprom_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .sk_rise  (sk_rise),
    .eng_busy (eng_busy),
    .state    (state),
    .do_oe    (do_oe),
    .wr_req   (wr_req)
);

// File: tb/mw_eeprom_slave_tb.sv
`timescale 1ns/1ps
module mw_eeprom_slave_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic        do_o, do_oe;
    logic [6:0]  rd_addr;
    logic [15:0] rd_data;
    logic        eng_busy;
    logic        wr_req;
    logic [1:0]  wr_kind;
    logic [6:0]  wr_addr;
    logic [15:0] wr_data;

    int n_chk = 0, n_fail = 0, req_cnt = 0, busy_cnt = 0;
    logic [1:0]  cap_kind;
    logic [6:0]  cap_addr;
    logic [15:0] cap_data;
    bit done = 0;

    always #4 clk = ~clk;

    mw_eeprom_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
        .do_o(do_o), .do_oe(do_oe), .rd_addr(rd_addr), .rd_data(rd_data),
        .eng_busy(eng_busy), .wr_req(wr_req), .wr_kind(wr_kind),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [15:0] word16(input logic [5:0] a);
        return {({2'b00, a} ^ 8'hC3), ~{2'b00, a}};
    endfunction

    function automatic logic [7:0] byte8(input logic [6:0] a);
        logic [7:0] t;
        t = {1'b0, a};
        return t * 8'd7 + 8'h11;
    endfunction

    always_comb rd_data = org ? word16(rd_addr[5:0]) : {8'h00, byte8(rd_addr)};

    // Write engine model: busy for 300 cycles after each request
    assign eng_busy = (busy_cnt != 0);
    always @(posedge clk) begin
        if (wr_req) begin
            req_cnt  <= req_cnt + 1;
            cap_kind <= wr_kind;
            cap_addr <= wr_addr;
            cap_data <= wr_data;
            busy_cnt <= 300;
        end else if (busy_cnt != 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        di = b;
        repeat (4) @(negedge clk);
        sk = 1'b1;
        repeat (6) @(negedge clk);
        sk = 1'b0;
    endtask

    task automatic sel();
        cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        sk = 1'b0; di = 1'b0; cs = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic grab(input int n, output logic [31:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            pulse(1'b0);
            v = {v[30:0], do_o};
        end
    endtask

    task automatic rd_cmd(input logic o, input logic [6:0] a);
        org = o;
        sel();
        send(32'b110, 3);
        send({25'd0, a}, o ? 6 : 7);
    endtask

    task automatic wait_ready();
        while (eng_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic special(input logic o, input logic [1:0] sub);
        org = o;
        sel();
        send(32'b100, 3);
        if (o) send({26'd0, sub, 4'd0}, 6);
        else   send({25'd0, sub, 5'd0}, 7);
    endtask

    task automatic wr_word(input logic o, input logic [6:0] a, input logic [15:0] d);
        org = o;
        sel();
        send(32'b101, 3);
        send({25'd0, a}, o ? 6 : 7);
        send({16'd0, d}, o ? 16 : 8);
        desel();
    endtask

    localparam logic [7:0] RD_VEC [8] = '{
        {1'b1, 7'd0},  {1'b1, 7'd21}, {1'b1, 7'd63}, {1'b1, 7'd42},
        {1'b0, 7'd0},  {1'b0, 7'd64}, {1'b0, 7'd127}, {1'b0, 7'd85}
    };

    initial begin
        logic [31:0] v;
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk("R1 oe after reset", {31'd0, do_oe}, 32'd0);
        chk("R1 no request after reset", req_cnt, 0);
        sel();
        chk("R1 oe selected without pending status", {31'd0, do_oe}, 32'd0);
        desel();

        // R3: table of reads in both organizations
        foreach (RD_VEC[k]) begin
            rd_cmd(RD_VEC[k][7], RD_VEC[k][6:0]);
            chk("R3 dummy zero", {30'd0, do_oe, do_o}, 32'b10);
            if (RD_VEC[k][7]) begin
                grab(16, v);
                chk("R3 wide word", v, {16'd0, word16(RD_VEC[k][5:0])});
            end else begin
                grab(8, v);
                chk("R3 half word", v, {24'd0, byte8(RD_VEC[k][6:0])});
            end
            desel();
            chk("R1 oe after deselect", {31'd0, do_oe}, 32'd0);
        end

        // R2: leading zeros before start bit
        org = 1'b1;
        sel();
        send(32'b000, 3);
        send(32'b110, 3);
        send(32'd9, 6);
        chk("R2 dummy after leading zeros", {30'd0, do_oe, do_o}, 32'b10);
        grab(16, v);
        chk("R2 word after leading zeros", v, {16'd0, word16(6'd9)});
        desel();

        // R4: sequential read with wrap
        rd_cmd(1'b1, 7'd63);
        grab(16, v); chk("R4 wide last word", v, {16'd0, word16(6'd63)});
        grab(16, v); chk("R4 wide wrap to 0", v, {16'd0, word16(6'd0)});
        grab(16, v); chk("R4 wide next 1", v, {16'd0, word16(6'd1)});
        desel();
        rd_cmd(1'b0, 7'd126);
        grab(8, v); chk("R4 half 126", v, {24'd0, byte8(7'd126)});
        grab(8, v); chk("R4 half 127", v, {24'd0, byte8(7'd127)});
        grab(8, v); chk("R4 half wrap to 0", v, {24'd0, byte8(7'd0)});
        desel();

        // R5: write while disabled after reset
        wr_word(1'b1, 7'd3, 16'h1234);
        chk("R5 no request when disabled", req_cnt, 0);
        sel();
        chk("R5 no status when disabled", {31'd0, do_oe}, 32'd0);
        desel();

        // R6: enable then write
        special(1'b1, 2'b11);
        desel();
        wr_word(1'b1, 7'd10, 16'hBEEF);
        chk("R6 request issued", req_cnt, 1);
        chk("R11 single cycle request", req_cnt, 1);
        chk("R6 kind", {30'd0, cap_kind}, 32'd0);
        chk("R6 addr", {25'd0, cap_addr}, 32'd10);
        chk("R6 data", {16'd0, cap_data}, 32'h0000BEEF);

        // R9: status poll
        sel();
        chk("R9 busy status", {30'd0, do_oe, do_o}, 32'b10);
        wait_ready();
        chk("R9 ready status", {30'd0, do_oe, do_o}, 32'b11);
        pulse(1'b1);
        chk("R9 start bit releases output", {31'd0, do_oe}, 32'd0);
        send(32'b10, 2);
        send(32'd4, 6);
        chk("R9 read after status dummy", {30'd0, do_oe, do_o}, 32'b10);
        grab(16, v);
        chk("R9 read after status word", v, {16'd0, word16(6'd4)});
        desel();

        // R7: clear word, clear all, fill all
        org = 1'b0;
        sel();
        send(32'b111, 3);
        send(32'd100, 7);
        desel();
        chk("R7 clear word count", req_cnt, 2);
        chk("R7 clear word kind", {30'd0, cap_kind}, 32'd1);
        chk("R7 clear word addr", {25'd0, cap_addr}, 32'd100);
        wait_ready();
        special(1'b1, 2'b10);
        desel();
        chk("R7 clear all count", req_cnt, 3);
        chk("R7 clear all kind", {30'd0, cap_kind}, 32'd2);
        wait_ready();
        special(1'b0, 2'b01);
        send(32'h5A, 8);
        desel();
        chk("R7 fill all count", req_cnt, 4);
        chk("R7 fill all kind", {30'd0, cap_kind}, 32'd3);
        chk("R7 fill all data", {16'd0, cap_data}, 32'h5A);
        wait_ready();

        // R8: partial instructions discarded
        base = req_cnt;
        org = 1'b1;
        sel();
        send(32'b101, 3);
        send(32'b010, 3);
        desel();
        chk("R8 partial address discarded", req_cnt, base);
        sel();
        send(32'b101, 3);
        send(32'd12, 6);
        send(32'hA5, 8);
        desel();
        chk("R8 partial data discarded", req_cnt, base);
        rd_cmd(1'b1, 7'd20);
        chk("R8 decode restarts dummy", {30'd0, do_oe, do_o}, 32'b10);
        grab(16, v);
        chk("R8 decode restarts word", v, {16'd0, word16(6'd20)});
        desel();

        // R5: disable again
        special(1'b1, 2'b00);
        desel();
        wr_word(1'b1, 7'd5, 16'h0F0F);
        chk("R5 disabled after lock", req_cnt, base);

        // R10: start bits ignored while busy
        special(1'b1, 2'b11);
        desel();
        wr_word(1'b1, 7'd7, 16'hAAAA);
        chk("R10 request before busy test", req_cnt, base + 1);
        sel();
        send(32'b110, 3);
        send(32'd5, 6);
        chk("R10 status still shown", {30'd0, do_oe, do_o}, 32'b10);
        grab(3, v);
        chk("R10 no read data while busy", v, 32'd0);
        chk("R10 output still enabled", {31'd0, do_oe}, 32'd1);
        desel();
        wait_ready();

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule